// File: doc/BRIEF.md
# Lead-Acid Battery Charge/Discharge Sequencer

This block decides whether a 12 V lead-acid battery is being charged or is supplying a load. It drives a charge switch and a discharge switch, and it reads the battery through an external 8-bit ADC using a start/done handshake. Two mutually exclusive state flags show which half of the cycle is active. A full-charge code and an empty code form a hysteresis loop between the two halves. By default, full charge (12.7 V) is code 251 and the 11 V floor is code 217.

The charger never measures the battery while current is flowing into it. Before every reading taken while charging, the charge switch is opened for a fixed settle interval (1005 clocks by default), so the sample shows the rest voltage. Only after that interval is a conversion requested. While discharging, the discharge switch stays closed, and the battery is sampled once per run interval. The block leaves reset in the charging state with both switches open, and it takes a settled reading first.

Top module: `batt_charge_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it, the charging flag reads 1, the discharging flag reads 0, both switches are open (0) and the conversion request is low.
- R2: In the charging state, the conversion request is raised only after the charge switch has been open for exactly SETTLE_CYCLES consecutive cycles. The switch stays open until the conversion returns.
- R3: The conversion request is a one-cycle pulse. No new request is made while a conversion is outstanding.
- R4: Suppose a reading returned while charging is greater than or equal to FULL_CODE. On the next cycle, the charging flag is 0, the discharging flag is 1 and the discharge switch is closed.
- R5: Suppose a reading returned while charging is below FULL_CODE. On the next cycle the block is still charging and the charge switch is closed. It stays closed for RUN_CYCLES cycles before the next settle interval.
- R6: Suppose a reading returned while discharging is less than or equal to EMPTY_CODE. On the next cycle, the discharging flag is 0, the charging flag is 1, the discharge switch is open and the charge switch is closed.
- R7: Suppose a reading returned while discharging is above EMPTY_CODE. The block stays discharging with the discharge switch closed. The next request comes RUN_CYCLES cycles after that reading returned.
- R8: Exactly one flag is set at all times. A switch is closed only while its own flag is set.
- R9: A done pulse that arrives while no conversion is outstanding changes no flag and no switch.
- R10: The ADC data is taken only in the cycle in which done is high with a conversion outstanding. Other values on the data bus have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adc_data | input | DATA_W | Battery voltage code from the ADC |
| adc_done | input | 1 | One-cycle conversion-complete pulse |
| adc_start | output | 1 | One-cycle conversion request |
| chg_sw | output | 1 | Charge switch, 1 = closed |
| dis_sw | output | 1 | Discharge switch, 1 = closed |
| chg_flag | output | 1 | Charging state flag |
| dis_flag | output | 1 | Discharging state flag |

## Verification
The bound checker checks the following on every cycle:
- the flags are exclusive;
- the switches agree with their flags;
- the request is a single pulse with no request during an outstanding conversion;
- the settle count that precedes each charging request matches SETTLE_CYCLES;
- the flags respond to each returned reading on the next cycle.

The bench's scenarios cover the rest. They sweep every 8-bit code through both halves of the loop, so both threshold edges are hit from each side. They inject stray done pulses in each state. They hold misleading values on the data bus outside the done cycle. They measure the closed-switch run lengths between readings.

// File: rtl/batt_pkg.sv
package batt_pkg;

   typedef enum logic [1:0] {
      PH_CHG_RUN    = 2'd0,
      PH_CHG_SETTLE = 2'd1,
      PH_MEASURE    = 2'd2,
      PH_DIS_RUN    = 2'd3
   } batt_phase_t;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/batt_interval_timer.sv
module batt_interval_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run,
   input  logic [CNT_W-1:0] limit,
   output logic             expire
);

   logic [CNT_W-1:0] cnt;

   assign expire = run && (cnt == (limit - 1'b1));

   always_ff @(posedge clk) begin
      if (rst || !run || expire)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/batt_adc_seq.sv
module batt_adc_seq #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              go,
   input  logic              adc_done,
   input  logic [DATA_W-1:0] adc_data,
   output logic              adc_start,
   output logic              result_valid,
   output logic [DATA_W-1:0] result
);

   logic pend;

   always_ff @(posedge clk) begin
      if (rst) begin
         adc_start <= 1'b0;
         pend      <= 1'b0;
      end else begin
         adc_start <= go && !pend && !adc_start;
         if (adc_start)
            pend <= 1'b1;
         else if (pend && adc_done)
            pend <= 1'b0;
      end
   end

   assign result_valid = pend && adc_done;
   assign result       = adc_data;

endmodule

// File: rtl/batt_level_judge.sv
module batt_level_judge #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned FULL_CODE  = 251,
   parameter int unsigned EMPTY_CODE = 217
) (
   input  logic [DATA_W-1:0] code,
   output logic              is_full,
   output logic              is_empty
);

   localparam int unsigned CODE_MAX = (1 << DATA_W) - 1;
   localparam logic [DATA_W-1:0] FULL_L  = FULL_CODE[DATA_W-1:0];
   localparam logic [DATA_W-1:0] EMPTY_L = EMPTY_CODE[DATA_W-1:0];

   generate
      if (FULL_CODE == CODE_MAX) begin : g_full_top
         assign is_full = &code;
      end else begin : g_full_cmp
         assign is_full = (code >= FULL_L);
      end
      if (EMPTY_CODE == 0) begin : g_empty_zero
         assign is_empty = ~|code;
      end else begin : g_empty_cmp
         assign is_empty = (code <= EMPTY_L);
      end
   endgenerate

endmodule

// File: rtl/batt_charge_ctrl.sv
module batt_charge_ctrl
   import batt_pkg::*;
#(
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned SETTLE_CYCLES = 1005,
   parameter int unsigned RUN_CYCLES    = 1005,
   parameter int unsigned FULL_CODE     = 251,
   parameter int unsigned EMPTY_CODE    = 217
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] adc_data,
   input  logic              adc_done,
   output logic              adc_start,
   output logic              chg_sw,
   output logic              dis_sw,
   output logic              chg_flag,
   output logic              dis_flag
);

   localparam int unsigned LIMIT_MAX = max_u(SETTLE_CYCLES, RUN_CYCLES);
   localparam int unsigned CNT_W     = $clog2(LIMIT_MAX + 1);
   localparam logic [CNT_W-1:0] SETTLE_L = SETTLE_CYCLES[CNT_W-1:0];
   localparam logic [CNT_W-1:0] RUN_L    = RUN_CYCLES[CNT_W-1:0];

   generate
      if (DATA_W < 2 || DATA_W > 16) begin : g_bad_width
         $error("batt_charge_ctrl: DATA_W out of range");
      end
      if (FULL_CODE <= EMPTY_CODE) begin : g_bad_thresh
         $error("batt_charge_ctrl: FULL_CODE must exceed EMPTY_CODE");
      end
      if (FULL_CODE >= (1 << DATA_W)) begin : g_bad_full
         $error("batt_charge_ctrl: FULL_CODE does not fit DATA_W");
      end
      if (SETTLE_CYCLES < 1 || RUN_CYCLES < 2) begin : g_bad_time
         $error("batt_charge_ctrl: interval lengths too short");
      end
   endgenerate

   batt_phase_t phase_q, phase_d;
   logic        chg_q, dis_q, chg_d, dis_d;
   logic        tmr_run, tmr_expire, meas_go;
   logic [CNT_W-1:0] tmr_limit;
   logic        res_valid, res_full, res_empty;
   logic [DATA_W-1:0] res_code;

   assign tmr_run   = (phase_q != PH_MEASURE);
   assign tmr_limit = (phase_q == PH_CHG_SETTLE) ? SETTLE_L : RUN_L;
   assign meas_go   = tmr_expire && ((phase_q == PH_CHG_SETTLE) || (phase_q == PH_DIS_RUN));

   batt_interval_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk    (clk),
      .rst    (rst),
      .run    (tmr_run),
      .limit  (tmr_limit),
      .expire (tmr_expire)
   );

   batt_adc_seq #(.DATA_W(DATA_W)) u_adc (
      .clk          (clk),
      .rst          (rst),
      .go           (meas_go),
      .adc_done     (adc_done),
      .adc_data     (adc_data),
      .adc_start    (adc_start),
      .result_valid (res_valid),
      .result       (res_code)
   );

   batt_level_judge #(
      .DATA_W     (DATA_W),
      .FULL_CODE  (FULL_CODE),
      .EMPTY_CODE (EMPTY_CODE)
   ) u_judge (
      .code     (res_code),
      .is_full  (res_full),
      .is_empty (res_empty)
   );

   always_comb begin
      phase_d = phase_q;
      chg_d   = chg_q;
      dis_d   = dis_q;
      unique case (phase_q)
         PH_CHG_RUN:    if (tmr_expire) phase_d = PH_CHG_SETTLE;
         PH_CHG_SETTLE: if (tmr_expire) phase_d = PH_MEASURE;
         PH_DIS_RUN:    if (tmr_expire) phase_d = PH_MEASURE;
         PH_MEASURE: begin
            if (res_valid) begin
               if (chg_q) begin
                  if (res_full) begin
                     chg_d   = 1'b0;
                     dis_d   = 1'b1;
                     phase_d = PH_DIS_RUN;
                  end else begin
                     phase_d = PH_CHG_RUN;
                  end
               end else begin
                  if (res_empty) begin
                     chg_d   = 1'b1;
                     dis_d   = 1'b0;
                     phase_d = PH_CHG_RUN;
                  end else begin
                     phase_d = PH_DIS_RUN;
                  end
               end
            end
         end
         default: phase_d = PH_CHG_SETTLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_CHG_SETTLE;
         chg_q   <= 1'b1;
         dis_q   <= 1'b0;
      end else begin
         phase_q <= phase_d;
         chg_q   <= chg_d;
         dis_q   <= dis_d;
      end
   end

   assign chg_flag = chg_q;
   assign dis_flag = dis_q;
   assign chg_sw   = chg_q && (phase_q == PH_CHG_RUN);
   assign dis_sw   = dis_q;

endmodule

// File: rtl/batt_charge_ctrl_chk.sv
module batt_charge_ctrl_chk #(
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned SETTLE_CYCLES = 1005,
   parameter int unsigned FULL_CODE     = 251,
   parameter int unsigned EMPTY_CODE    = 217
) (
   input logic              clk,
   input logic              rst,
   input logic [DATA_W-1:0] adc_data,
   input logic              adc_done,
   input logic              adc_start,
   input logic              chg_sw,
   input logic              dis_sw,
   input logic              chg_flag,
   input logic              dis_flag
);

   localparam logic [DATA_W-1:0] FULL_L  = FULL_CODE[DATA_W-1:0];
   localparam logic [DATA_W-1:0] EMPTY_L = EMPTY_CODE[DATA_W-1:0];

   logic        pend;
   int unsigned low_cnt;

   always_ff @(posedge clk) begin
      if (rst)
         pend <= 1'b0;
      else if (adc_start)
         pend <= 1'b1;
      else if (adc_done)
         pend <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst || chg_sw || !chg_flag || pend || adc_start)
         low_cnt <= 0;
      else
         low_cnt <= low_cnt + 1;
   end

   assert_one_flag_R8: assert property (@(posedge clk) disable iff (rst)
      $countones({chg_flag, dis_flag}) == 1);
   assert_chg_sw_own_R8: assert property (@(posedge clk) disable iff (rst)
      chg_sw |-> chg_flag);
   assert_dis_sw_own_R8: assert property (@(posedge clk) disable iff (rst)
      dis_sw |-> dis_flag);
   assert_start_pulse_R3: assert property (@(posedge clk) disable iff (rst)
      adc_start |=> !adc_start);
   assert_no_restart_R3: assert property (@(posedge clk) disable iff (rst)
      pend |-> !adc_start);
   assert_open_while_pending_R2: assert property (@(posedge clk) disable iff (rst)
      pend |-> !chg_sw);
   assert_settle_len_R2: assert property (@(posedge clk) disable iff (rst)
      (adc_start && chg_flag) |-> (low_cnt == SETTLE_CYCLES));
   assert_full_swap_R4: assert property (@(posedge clk) disable iff (rst)
      (pend && adc_done && chg_flag && (adc_data >= FULL_L)) |=> (dis_flag && dis_sw));
   assert_stay_charging_R5: assert property (@(posedge clk) disable iff (rst)
      (pend && adc_done && chg_flag && (adc_data < FULL_L)) |=> (chg_flag && chg_sw));
   assert_empty_return_R6: assert property (@(posedge clk) disable iff (rst)
      (pend && adc_done && dis_flag && (adc_data <= EMPTY_L)) |=> (chg_flag && chg_sw && !dis_sw));
   assert_stay_discharging_R7: assert property (@(posedge clk) disable iff (rst)
      (pend && adc_done && dis_flag && (adc_data > EMPTY_L)) |=> (dis_flag && dis_sw));
   assert_flags_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !(pend && adc_done) |=> ($stable(chg_flag) && $stable(dis_flag)));

endmodule

bind batt_charge_ctrl batt_charge_ctrl_chk #(
   .DATA_W        (DATA_W),
   .SETTLE_CYCLES (SETTLE_CYCLES),
   .FULL_CODE     (FULL_CODE),
   .EMPTY_CODE    (EMPTY_CODE)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .adc_data  (adc_data),
   .adc_done  (adc_done),
   .adc_start (adc_start),
   .chg_sw    (chg_sw),
   .dis_sw    (dis_sw),
   .chg_flag  (chg_flag),
   .dis_flag  (dis_flag)
);

// File: tb/sim_batt_charge_ctrl.sv
`timescale 1ns/1ps
module sim_batt_charge_ctrl;

   localparam int DW     = 8;
   localparam int SETTLE = 3;
   localparam int RUN    = 4;
   localparam int FULL   = 251;
   localparam int EMPTY  = 217;

   logic          clk = 1'b0;
   logic          rst;
   logic [DW-1:0] adc_data;
   logic          adc_done;
   logic          adc_start, chg_sw, dis_sw, chg_flag, dis_flag;

   int checks = 0;
   int fails  = 0;
   bit done_all = 1'b0;

   always #2 clk = ~clk;

   batt_charge_ctrl #(
      .DATA_W(DW), .SETTLE_CYCLES(SETTLE), .RUN_CYCLES(RUN),
      .FULL_CODE(FULL), .EMPTY_CODE(EMPTY)
   ) u0 (
      .clk(clk), .rst(rst), .adc_data(adc_data), .adc_done(adc_done),
      .adc_start(adc_start), .chg_sw(chg_sw), .dis_sw(dis_sw),
      .chg_flag(chg_flag), .dis_flag(dis_flag)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // port-level monitor, sampled 1 ns after each falling edge
   bit pend = 1'b0, prev_start = 1'b0, prev_sw = 1'b0;
   int low_cnt = 0, dis_cnt = 0, hi_cnt = 0;
   always @(negedge clk) begin
      #1;
      if (rst) begin
         pend = 0; prev_start = 0; prev_sw = 0;
         low_cnt = 0; dis_cnt = 0; hi_cnt = 0;
      end else begin
         if ((chg_flag ^ dis_flag) !== 1'b1)
            chk(0, "R8 flags not exclusive", {chg_flag, dis_flag}, 1);
         if ((chg_sw && !chg_flag) || (dis_sw && !dis_flag))
            chk(0, "R8 switch without its flag", {chg_sw, dis_sw}, 0);
         if (adc_start) begin
            chk(!prev_start && !pend, "R3 start pulse", {prev_start, pend}, 0);
            if (chg_flag) chk(low_cnt == SETTLE, "R2 settle length", low_cnt, SETTLE);
            else          chk(dis_cnt == RUN, "R7 discharge interval", dis_cnt, RUN);
         end
         if (pend && chg_sw) chk(0, "R2 switch closed while converting", 1, 0);
         if (chg_flag && prev_sw && !chg_sw)
            chk(hi_cnt == RUN, "R5 charge run length", hi_cnt, RUN);
         low_cnt = (chg_sw || !chg_flag || pend || adc_start) ? 0 : low_cnt + 1;
         hi_cnt  = chg_sw ? hi_cnt + 1 : 0;
         if (!dis_flag || adc_start || (pend && adc_done)) dis_cnt = 0;
         else dis_cnt = dis_cnt + 1;
         if (adc_start) pend = 1;
         else if (pend && adc_done) pend = 0;
         prev_start = adc_start;
         prev_sw    = chg_sw;
      end
   end

   // ADC responder: waits for a request, answers after lat cycles
   task automatic measure(input logic [DW-1:0] code, input int lat);
      do begin
         @(negedge clk); #1;
      end while (!adc_start);
      adc_data = ~code;
      repeat (lat - 1) @(negedge clk);
      @(negedge clk);
      adc_done = 1'b1;
      adc_data = code;
      @(negedge clk);
      adc_done = 1'b0;
      adc_data = ~code;
      #1;
   endtask

   task automatic stray_done(input logic [DW-1:0] code);
      @(negedge clk);
      adc_done = 1'b1;
      adc_data = code;
      @(negedge clk);
      adc_done = 1'b0;
      #1;
   endtask

   initial begin
      rst = 1'b1; adc_done = 1'b0; adc_data = '0;
      repeat (3) @(negedge clk);
      #1;
      chk(chg_flag && !dis_flag && !chg_sw && !dis_sw && !adc_start,
          "R1 state in reset", {chg_flag, dis_flag, chg_sw, dis_sw, adc_start}, 5'b10000);
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk(chg_flag && !dis_flag && !chg_sw && !dis_sw && !adc_start,
          "R1 state after reset", {chg_flag, dis_flag, chg_sw, dis_sw, adc_start}, 5'b10000);
      // R9: stray done during settle must be ignored
      adc_done = 1'b1; adc_data = 8'hFF;
      @(negedge clk);
      adc_done = 1'b0;
      #1;
      chk(chg_flag && !dis_flag && !chg_sw && !adc_start, "R9 stray done in settle",
          {chg_flag, dis_flag, chg_sw}, 3'b100);

      // charging sweep over every code
      for (int c = 0; c < 256; c++) begin
         measure(c[DW-1:0], 1 + (c % 3));
         if (c >= FULL) begin
            chk(dis_flag && !chg_flag && dis_sw && !chg_sw, "R4 full swaps to discharge",
                {chg_flag, dis_flag, chg_sw, dis_sw}, 4'b0101);
            measure(EMPTY[DW-1:0], 2);
            chk(chg_flag && chg_sw && !dis_sw, "R6 empty returns to charge",
                {chg_flag, dis_flag, chg_sw, dis_sw}, 4'b1010);
         end else begin
            chk(chg_flag && !dis_flag && chg_sw, "R5 below full stays charging",
                {chg_flag, dis_flag, chg_sw, dis_sw}, 4'b1010);
            if (c == 100) begin
               stray_done(8'hFF);
               chk(chg_flag && chg_sw && !dis_flag, "R9 stray done in charge run",
                   {chg_flag, dis_flag, chg_sw}, 3'b101);
            end
         end
      end

      // enter discharge, then sweep every code downward
      measure(8'hFF, 1);
      chk(dis_flag && dis_sw, "R4 entry by top code", {chg_flag, dis_flag}, 2'b01);
      stray_done(8'h00);
      chk(dis_flag && dis_sw && !chg_flag, "R9 stray done in discharge",
          {chg_flag, dis_flag, dis_sw}, 3'b011);
      for (int c = 255; c >= 0; c--) begin
         measure(c[DW-1:0], 1 + (c % 3));
         if (c <= EMPTY) begin
            chk(chg_flag && !dis_flag && chg_sw && !dis_sw, "R6 empty returns to charge",
                {chg_flag, dis_flag, chg_sw, dis_sw}, 4'b1010);
            measure(FULL[DW-1:0], 3);
            chk(dis_flag && dis_sw, "R4 full threshold edge", {chg_flag, dis_flag}, 2'b01);
         end else begin
            chk(dis_flag && !chg_flag && dis_sw, "R7 above empty stays discharging",
                {chg_flag, dis_flag, chg_sw, dis_sw}, 4'b0101);
         end
      end
      // R10: data bus changes outside done cycle after a settled reading had no effect
      chk(dis_flag && dis_sw, "R10 final state", {chg_flag, dis_flag}, 2'b01);
      done_all = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done_all);
            repeat (2) @(negedge clk);
         end
         begin
            repeat (150000) @(posedge clk);
            chk(0, "watchdog expired", 0, 1);
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule